// File: doc/BRIEF.md
# Serial Configuration Port Mode Selector

This block sits behind the three serial pins of a configuration port and decides what those pins mean. Out of power-on reset the pins are plain static option inputs: with chip select idle high, the levels on the clock, data and return-data pins are carried, after synchronisation, straight to the option outputs. Pulling chip select low hands the option outputs over to a small internal register bank. The pins are then read as a serial command stream.

A one-way mode latch watches each selection and counts rising serial-clock edges. On the ninth edge of a single selection (a command byte plus one cycle) the latch sets. From then on the option outputs come only from the register bank, whatever chip select does. Only the power-on reset or the hardware reset pin clears the latch. The soft reset strobe clears the register contents and leaves the latch alone. A selection that ends before the ninth edge commits nothing and the pins return to their static role.

The serial side is a 16-bit frame, MSB first, sampled on rising serial-clock edges. Write frames load a register. Read frames return a register on the data-out pin during the second byte. The output enable of that pin is low at all other times.

Top module: `cfg_port_front`

## Requirements
- R1: While `rst` is high and after it falls, `spi_mode` is 0, `sdo_oe` is 0 and `opt_out` is 0 until pin levels propagate.
- R2: With `csb` high and the latch clear, `opt_out` equals {`sdo_in`,`sdio`,`sclk`} (bit 2 down to bit 0) within 3 clock cycles of a pin change.
- R3: While `csb` is low, `opt_out` equals bits [2:0] of register 0 and changes on the three pins have no effect on it.
- R4: `spi_mode` stays 0 through the eighth rising `sclk` edge of a selection and becomes 1 after the ninth rising edge of that same selection.
- R5: Raising `csb` before the ninth edge clears the edge count. `opt_out` returns to the pin levels, and a later selection needs nine fresh edges to commit.
- R6: Once `spi_mode` is 1, `opt_out` follows register 0 bits [2:0] whatever `csb` and the pins do.
- R7: A one-cycle pulse on `soft_rst` clears every register to 0 and leaves `spi_mode` unchanged.
- R8: A pulse on `hrst` or on `rst` returns `spi_mode` to 0 and `opt_out` to the pin levels.
- R9: A frame is 16 bits sent MSB first while `csb` is low. Bit 15 is 1 for read and 0 for write, bits 14:8 are the address, and bits 7:0 are the data. A write frame to address 0 to 3 stores its data byte at that address.
- R10: In a read frame, `sdo_oe` is 1 during the data byte. `sdo_out` gives the addressed register MSB first, valid before each of rising edges 9 to 16. `sdo_oe` is 0 outside a read data byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst | input | 1 | Power-on reset, synchronous, active high |
| hrst | input | 1 | Hardware reset pin, synchronous, active high |
| soft_rst | input | 1 | Register-bank clear strobe |
| csb | input | 1 | Chip select, active low |
| sclk | input | 1 | Serial clock, or static option bit 0 |
| sdio | input | 1 | Serial data in, or static option bit 1 |
| sdo_in | input | 1 | Level on the data-out pin, used as static option bit 2 |
| sdo_out | output | 1 | Serial read data |
| sdo_oe | output | 1 | Drive enable for the data-out pin; pin floats when low |
| opt_out | output | 3 | Option controls |
| spi_mode | output | 1 | Mode latch: 0 pin mode, 1 serial mode |

## Verification
If the mode latch sets early, the pins stop steering `opt_out` after a short selection. If it fails to set, they take control back as soon as `csb` rises. Either fault shows on `opt_out` three cycles after `csb` rises, and `spi_mode` shows it one cycle after the commit edge. A miscounted bit position corrupts the stored data byte. That shows at the next read-back, either on `opt_out` for register 0 or in the serial data of a read frame. A soft reset that reaches the latch shows as a fall on `spi_mode` and a return to the pin levels.

// File: rtl/cfg_pkg.sv
package cfg_pkg;
  localparam int FRAME_BITS = 16;
  localparam int CMD_BITS   = 8;
  localparam int ADDR_W     = CMD_BITS - 1;
  localparam int DATA_W     = FRAME_BITS - CMD_BITS;
  localparam int BCNT_W     = $clog2(FRAME_BITS + 1);

  typedef struct packed {
    logic              rd;
    logic [ADDR_W-1:0] addr;
  } cmd_t;
endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
  parameter int             W       = 4,
  parameter int             STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst)         stg[i] <= RST_VAL;
      else if (i == 0) stg[i] <= d;
      else             stg[i] <= stg[(i == 0) ? 0 : i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/mode_latch.sv
module mode_latch #(
  parameter int COMMIT = 9
) (
  input  logic clk,
  input  logic clr,
  input  logic csb_s,
  input  logic edge_i,
  output logic latched
);
  localparam int CW = $clog2(COMMIT + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (clr) begin
      cnt     <= '0;
      latched <= 1'b0;
    end else if (csb_s) begin
      cnt <= '0;
    end else if (edge_i && !latched) begin
      if (cnt == CW'(COMMIT - 1)) begin
        latched <= 1'b1;
        cnt     <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assert_commit_count_R4: assert property (@(posedge clk) disable iff (clr)
    $rose(latched) |-> ($past(cnt) == CW'(COMMIT - 1)) && $past(edge_i));

  assert_count_clear_R5: assert property (@(posedge clk) disable iff (clr)
    csb_s |=> (cnt == '0));

  assert_count_bound_R5: assert property (@(posedge clk) disable iff (clr)
    cnt <= CW'(COMMIT - 1));
endmodule

// File: rtl/spi_regs.sv
module spi_regs
  import cfg_pkg::*;
#(
  parameter int N_REGS = 4,
  parameter int NOPT   = 3
) (
  input  logic            clk,
  input  logic            rst_hw,
  input  logic            soft_rst,
  input  logic            csb_s,
  input  logic            sdio_s,
  input  logic            edge_i,
  output logic [NOPT-1:0] reg_opt,
  output logic            sdo_out,
  output logic            sdo_oe
);
  localparam int IW = $clog2(N_REGS);

  logic [DATA_W-1:0] regs [N_REGS];
  logic [BCNT_W-1:0] bitcnt;
  logic [CMD_BITS-2:0] cmd_sh;
  logic [DATA_W-2:0] data_sh;
  logic [DATA_W-1:0] out_sh;
  cmd_t              cmd_q;
  cmd_t              cmd_nxt;
  logic              last_cmd_bit;
  logic              last_data_bit;
  logic              in_data;

  assign cmd_nxt       = {cmd_sh, sdio_s};
  assign last_cmd_bit  = edge_i && (bitcnt == BCNT_W'(CMD_BITS - 1));
  assign last_data_bit = edge_i && (bitcnt == BCNT_W'(FRAME_BITS - 1));
  assign in_data       = (bitcnt >= BCNT_W'(CMD_BITS)) && (bitcnt < BCNT_W'(FRAME_BITS));

  always_ff @(posedge clk) begin
    if (rst_hw) begin
      bitcnt  <= '0;
      cmd_sh  <= '0;
      data_sh <= '0;
      out_sh  <= '0;
      cmd_q   <= '0;
      sdo_out <= 1'b0;
      sdo_oe  <= 1'b0;
    end else begin
      if (csb_s) begin
        bitcnt <= '0;
        cmd_q  <= '0;
      end else if (edge_i) begin
        if (bitcnt < BCNT_W'(FRAME_BITS)) bitcnt <= bitcnt + 1'b1;
        if (bitcnt < BCNT_W'(CMD_BITS)) begin
          cmd_sh <= {cmd_sh[CMD_BITS-3:0], sdio_s};
        end else if (in_data) begin
          data_sh <= {data_sh[DATA_W-3:0], sdio_s};
          out_sh  <= {out_sh[DATA_W-2:0], 1'b0};
        end
        if (last_cmd_bit) begin
          cmd_q  <= cmd_nxt;
          out_sh <= (cmd_nxt.addr < ADDR_W'(N_REGS)) ? regs[cmd_nxt.addr[IW-1:0]] : '0;
        end
      end
      sdo_out <= out_sh[DATA_W-1];
      sdo_oe  <= cmd_q.rd && !csb_s && in_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst_hw || soft_rst) begin
      for (int i = 0; i < N_REGS; i++) regs[i] <= '0;
    end else if (!csb_s && last_data_bit && !cmd_q.rd &&
                 (cmd_q.addr < ADDR_W'(N_REGS))) begin
      regs[cmd_q.addr[IW-1:0]] <= {data_sh, sdio_s};
    end
  end

  assign reg_opt = regs[0][NOPT-1:0];

  assert_oe_selected_R10: assert property (@(posedge clk) disable iff (rst_hw)
    sdo_oe |-> $past(!csb_s));

  assert_soft_clear_R7: assert property (@(posedge clk) disable iff (rst_hw)
    soft_rst |=> (reg_opt == '0));
endmodule

// File: rtl/cfg_port_front.sv
module cfg_port_front #(
  parameter int NOPT    = 3,
  parameter int N_REGS  = 4,
  parameter int COMMIT  = 9,
  parameter int SYNC_ST = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            hrst,
  input  logic            soft_rst,
  input  logic            csb,
  input  logic            sclk,
  input  logic            sdio,
  input  logic            sdo_in,
  output logic            sdo_out,
  output logic            sdo_oe,
  output logic [NOPT-1:0] opt_out,
  output logic            spi_mode
);
  localparam int NPIN = 4;

  logic            clr;
  logic [NPIN-1:0] pins_s;
  logic            csb_s;
  logic [2:0]      pin_s;
  logic [NOPT-1:0] pin_opt;
  logic [NOPT-1:0] reg_opt;
  logic            sclk_q;
  logic            sclk_rise;
  logic            sel_spi;

  assign clr = rst | hrst;

  pin_sync #(.W(NPIN), .STAGES(SYNC_ST), .RST_VAL(4'b1000)) u_sync (
    .clk (clk),
    .rst (clr),
    .d   ({csb, sdo_in, sdio, sclk}),
    .q   (pins_s)
  );

  assign csb_s   = pins_s[3];
  assign pin_s   = pins_s[2:0];
  assign pin_opt = pin_s[NOPT-1:0];

  always_ff @(posedge clk) begin
    if (clr) sclk_q <= 1'b0;
    else     sclk_q <= pin_s[0];
  end

  assign sclk_rise = pin_s[0] & ~sclk_q & ~csb_s;

  mode_latch #(.COMMIT(COMMIT)) u_latch (
    .clk     (clk),
    .clr     (clr),
    .csb_s   (csb_s),
    .edge_i  (sclk_rise),
    .latched (spi_mode)
  );

  spi_regs #(.N_REGS(N_REGS), .NOPT(NOPT)) u_regs (
    .clk      (clk),
    .rst_hw   (clr),
    .soft_rst (soft_rst),
    .csb_s    (csb_s),
    .sdio_s   (pin_s[1]),
    .edge_i   (sclk_rise),
    .reg_opt  (reg_opt),
    .sdo_out  (sdo_out),
    .sdo_oe   (sdo_oe)
  );

  assign sel_spi = spi_mode | ~csb_s;

  always_ff @(posedge clk) begin
    if (clr) opt_out <= '0;
    else     opt_out <= sel_spi ? reg_opt : pin_opt;
  end

  assert_latch_sticky_R7: assert property (@(posedge clk) disable iff (clr)
    spi_mode |=> spi_mode);  // also covers R6: csb cannot release the latch

  assert_pin_path_R2: assert property (@(posedge clk) disable iff (clr)
    (csb_s && !spi_mode) |=> (opt_out == $past(pin_opt)));

  assert_reg_path_R3: assert property (@(posedge clk) disable iff (clr)
    (!csb_s || spi_mode) |=> (opt_out == $past(reg_opt)));

  assert_reset_state_R1: assert property (@(posedge clk)
    clr |=> (!spi_mode && !sdo_oe && (opt_out == '0)));
endmodule

// File: tb/sim_cfg_port_front.sv
module sim_cfg_port_front;
  localparam int HALF = 8;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       hrst = 1'b0;
  logic       soft_rst = 1'b0;
  logic       csb = 1'b1;
  logic       sclk = 1'b0;
  logic       sdio = 1'b0;
  logic       sdo_in = 1'b0;
  logic       sdo_out;
  logic       sdo_oe;
  logic [2:0] opt_out;
  logic       spi_mode;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  cfg_port_front u0 (
    .clk (clk), .rst (rst), .hrst (hrst), .soft_rst (soft_rst),
    .csb (csb), .sclk (sclk), .sdio (sdio), .sdo_in (sdo_in),
    .sdo_out (sdo_out), .sdo_oe (sdo_oe), .opt_out (opt_out), .spi_mode (spi_mode)
  );

  task automatic wait_clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic set_pins(input logic [2:0] p);
    {sdo_in, sdio, sclk} = p;
    wait_clks(4);
  endtask

  task automatic xfer(input logic [15:0] w, input int nbits, output logic [7:0] rdat,
                      output logic oe_all, output logic m8, output logic m9);
    rdat = '0; oe_all = 1'b1; m8 = 1'b0; m9 = 1'b0;
    sclk = 1'b0; csb = 1'b0;
    wait_clks(HALF);
    for (int b = 0; b < nbits; b++) begin
      sdio = w[15-b]; sclk = 1'b0;
      wait_clks(HALF);
      if (b >= 8) begin
        rdat[15-b] = sdo_out;
        oe_all = oe_all & sdo_oe;
      end
      sclk = 1'b1;
      wait_clks(HALF);
      if (b == 7) m8 = spi_mode;
      if (b == 8) m9 = spi_mode;
    end
    sclk = 1'b0;
    wait_clks(HALF);
    csb = 1'b1;
    wait_clks(HALF);
  endtask

  task automatic t_reset;
    chk("R1", "spi_mode in reset", {15'd0, spi_mode}, 16'd0);
    rst = 1'b0;
    wait_clks(1);
    chk("R1", "spi_mode after reset", {15'd0, spi_mode}, 16'd0);
    chk("R1", "sdo_oe after reset", {15'd0, sdo_oe}, 16'd0);
    chk("R1", "opt_out after reset", {13'd0, opt_out}, 16'd0);
  endtask

  task automatic t_pin;
    set_pins(3'b101);
    chk("R2", "opt 101", {13'd0, opt_out}, 16'h5);
    set_pins(3'b010);
    chk("R2", "opt 010", {13'd0, opt_out}, 16'h2);
  endtask

  task automatic t_select;
    set_pins(3'b111);
    csb = 1'b0;
    wait_clks(4);
    chk("R3", "opt with csb low", {13'd0, opt_out}, 16'h0);
    sdio = 1'b0; sdo_in = 1'b0;
    wait_clks(4);
    chk("R3", "pins ignored while selected", {13'd0, opt_out}, 16'h0);
    chk("R4", "no commit without edges", {15'd0, spi_mode}, 16'd0);
    sdio = 1'b1; sdo_in = 1'b1;
    csb = 1'b1;
    wait_clks(4);
    chk("R5", "pins back after deselect", {13'd0, opt_out}, 16'h7);
  endtask

  task automatic t_short;
    logic [7:0] rd; logic oe, m8, m9;
    xfer(16'h0000, 5, rd, oe, m8, m9);
    chk("R5", "no commit after 5 edges", {15'd0, spi_mode}, 16'd0);
    xfer(16'h0000, 5, rd, oe, m8, m9);
    chk("R5", "count restarts per selection", {15'd0, spi_mode}, 16'd0);
    set_pins(3'b011);
    chk("R5", "pin levels after short frames", {13'd0, opt_out}, 16'h3);
  endtask

  task automatic t_commit;
    logic [7:0] rd; logic oe, m8, m9;
    xfer({1'b0, 7'd0, 8'h06}, 16, rd, oe, m8, m9);
    chk("R4", "mode after 8th edge", {15'd0, m8}, 16'd0);
    chk("R4", "mode after 9th edge", {15'd0, m9}, 16'd1);
    set_pins(3'b001);
    chk("R6", "opt from register after deselect", {13'd0, opt_out}, 16'h6);
    csb = 1'b0;
    wait_clks(4);
    set_pins(3'b111);
    chk("R6", "opt stable with csb low", {13'd0, opt_out}, 16'h6);
    csb = 1'b1;
    wait_clks(4);
    chk("R6", "opt stable with csb high", {13'd0, opt_out}, 16'h6);
    chk("R6", "latch holds", {15'd0, spi_mode}, 16'd1);
  endtask

  task automatic t_read;
    logic [7:0] rd; logic oe, m8, m9;
    xfer({1'b1, 7'd0, 8'h00}, 16, rd, oe, m8, m9);
    chk("R10", "read reg0 data", {8'd0, rd}, 16'h06);
    chk("R10", "oe during data byte", {15'd0, oe}, 16'd1);
    chk("R10", "oe idle after frame", {15'd0, sdo_oe}, 16'd0);
    xfer({1'b0, 7'd1, 8'hA5}, 16, rd, oe, m8, m9);
    chk("R10", "oe low in write frame", {15'd0, oe}, 16'd0);
    xfer({1'b1, 7'd1, 8'h00}, 16, rd, oe, m8, m9);
    chk("R9", "write then read reg1", {8'd0, rd}, 16'hA5);
    chk("R9", "reg1 write leaves options", {13'd0, opt_out}, 16'h6);
  endtask

  task automatic t_soft;
    logic [7:0] rd; logic oe, m8, m9;
    soft_rst = 1'b1;
    wait_clks(1);
    soft_rst = 1'b0;
    wait_clks(4);
    chk("R7", "latch survives soft reset", {15'd0, spi_mode}, 16'd1);
    chk("R7", "options cleared", {13'd0, opt_out}, 16'h0);
    xfer({1'b1, 7'd1, 8'h00}, 16, rd, oe, m8, m9);
    chk("R7", "reg1 cleared", {8'd0, rd}, 16'h00);
  endtask

  task automatic t_hw;
    logic [7:0] rd; logic oe, m8, m9;
    set_pins(3'b101);
    hrst = 1'b1;
    wait_clks(1);
    hrst = 1'b0;
    wait_clks(4);
    chk("R8", "hrst clears latch", {15'd0, spi_mode}, 16'd0);
    chk("R8", "pins after hrst", {13'd0, opt_out}, 16'h5);
    xfer({1'b0, 7'd0, 8'h03}, 16, rd, oe, m8, m9);
    chk("R8", "recommit", {15'd0, spi_mode}, 16'd1);
    set_pins(3'b010);
    chk("R8", "opt from reg before por", {13'd0, opt_out}, 16'h3);
    rst = 1'b1;
    wait_clks(1);
    rst = 1'b0;
    wait_clks(4);
    chk("R8", "rst clears latch", {15'd0, spi_mode}, 16'd0);
    chk("R8", "pins after rst", {13'd0, opt_out}, 16'h2);
  endtask

  initial begin
    wait_clks(4);
    t_reset();
    t_pin();
    t_select();
    t_short();
    t_commit();
    t_read();
    t_soft();
    t_hw();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule